// File: doc/BRIEF.md
# Offload Engine Register Sequencer

This block brings up and runs a TCP offload engine as a passive-open server, using only the engine's register bus: an address, a write strobe, write data, and read data that the engine returns one cycle after it sees an address. A debounced push button starts the flow. The sequencer then writes the local and peer network identity into the engine, takes the engine out of reset, and polls the engine's busy flag until initialisation has finished. After that it waits for a remote client to open a connection.

A mode input fixes the direction of each connection. In transmit mode the sequencer programs the total byte count and the segment size, issues a send command, and polls busy until the data has gone out. It then closes the connection itself and polls busy again. In receive mode it stays silent while the client streams data, and returns to waiting as soon as the client closes the connection. After either path it is ready for the next connection without any new button press.

Register addresses (4-bit): reset 0x0, command 0x1, total length 0x2, packet length 0x3, local MAC low/high 0x4/0x5, local IP 0x6, local port 0x7, peer IP 0x8, peer port 0x9, peer MAC low/high 0xA/0xB. Busy is bit 0 of the command register. Command value 0 starts a send and value 3 closes the connection.

Top module: `offload_reg_seq`

## Requirements
- R1: During reset and while idle after reset, reg_wr_en stays 0 and no register is written.
- R2: A start_btn level counts as a press only after it has been held stable for 2^DEB_W cycles. A pulse shorter than that causes no write, and a held press yields exactly one start.
- R3: A start press in idle produces 8 writes on consecutive cycles, in this order: 0x4=0x02030405, 0x5=0x00000001, 0x6=0xC0A80B2A (192.168.11.42), 0x7=0x00000FA0 (4000), 0x8=0xC0A80B19 (192.168.11.25), 0x9=0, 0xA=0, 0xB=0.
- R4: The cycle after the last parameter write, the reset register 0x0 is written with 0.
- R5: Each busy wait drives address 0x1 and checks reg_rd_data bit 0 in the cycle after that address was presented. The wait ends only when bit 0 reads 0, and no write happens during the wait.
- R6: With mode_rx=0, a rising edge of conn_on while waiting for a connection produces three writes on consecutive cycles: 0x2=TX_TOTAL_LEN, then 0x3=packet length, then 0x1=0.
- R7: The packet length written to 0x3 is 1460 when pkt_jumbo=0 and 8960 when pkt_jumbo=1.
- R8: The close command (0x1=3) is written only after busy has read 0 following the send command. When busy reads 0 again, the block returns to waiting for a connection and serves the next rising edge of conn_on.
- R9: With mode_rx=1, no register is written while conn_on stays 1. When conn_on falls, the block returns to waiting for a connection.
- R10: A start press outside idle is ignored, so the parameters are not written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_btn | input | 1 | Raw start push button, active high |
| mode_rx | input | 1 | Connection direction: 0 transmit, 1 receive |
| pkt_jumbo | input | 1 | Segment size select: 0 gives 1460, 1 gives 8960 |
| conn_on | input | 1 | Engine reports an open connection |
| reg_rd_data | input | DATA_W | Engine read data for the address of the previous cycle |
| reg_addr | output | ADDR_W | Register address |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | DATA_W | Register write data |

## Verification
Some properties are checked by assertions on every cycle: the debounced press is a single-cycle pulse, and the parameter burst lasts exactly eight cycles before the reset write. A busy wait ends only on a command-register read with bit 0 clear, the send command comes directly after the packet length write, and a receive connection ends only on a low conn_on. A start outside idle never re-enters the parameter state. Other behaviour only the bench scenarios can show: the exact register values, the choice of segment size, the rejection of a short button glitch, the ordering of the close write after the send busy has cleared, and repeated mixed transmit and receive connections served back to back.

// File: rtl/ors_pkg.sv
package ors_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_SETP, ST_CLRRST, ST_WBUSY1, ST_WOPEN,
      ST_TXLEN, ST_PKTLEN, ST_TXCMD, ST_WBUSY2, ST_TXCLOSE,
      ST_TXEND, ST_WCLOSE, ST_RXEND
   } seq_state_e;

   localparam logic [3:0] A_RESET    = 4'h0;
   localparam logic [3:0] A_CMD      = 4'h1;
   localparam logic [3:0] A_TOTLEN   = 4'h2;
   localparam logic [3:0] A_PKTLEN   = 4'h3;
   localparam logic [3:0] A_SMAC_LO  = 4'h4;
   localparam logic [3:0] A_SMAC_HI  = 4'h5;
   localparam logic [3:0] A_SIP      = 4'h6;
   localparam logic [3:0] A_SPORT    = 4'h7;
   localparam logic [3:0] A_DIP      = 4'h8;
   localparam logic [3:0] A_DPORT    = 4'h9;
   localparam logic [3:0] A_DMAC_LO  = 4'hA;
   localparam logic [3:0] A_DMAC_HI  = 4'hB;

   localparam logic [3:0] CMD_SEND   = 4'h0;
   localparam logic [3:0] CMD_CLOSE  = 4'h3;

   localparam logic [15:0] SEG_STD   = 16'd1460;
   localparam logic [15:0] SEG_JUMBO = 16'd8960;

   localparam int CFG_WORDS = 8;

endpackage

// File: rtl/ors_debounce.sv
module ors_debounce #(
   parameter int CNT_W = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_raw,
   output logic press
);

   logic [1:0] sync_q;
   logic       lvl_q;
   logic       lvl_d1_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= 2'b00;
      else        sync_q <= {sync_q[0], btn_raw};
   end

   generate
      if (CNT_W == 0) begin : g_bypass
         always_ff @(posedge clk) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= sync_q[1];
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lvl_q <= 1'b0;
               cnt_q <= '0;
            end else if (sync_q[1] == lvl_q) begin
               cnt_q <= '0;
            end else if (&cnt_q) begin
               lvl_q <= sync_q[1];
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_d1_q <= 1'b0;
      else        lvl_d1_q <= lvl_q;
   end

   assign press = lvl_q & ~lvl_d1_q;

   // R2
   press_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      press |=> !press);

endmodule

// File: rtl/ors_cfg_table.sv
module ors_cfg_table #(
   parameter int          ADDR_W   = 4,
   parameter int          DATA_W   = 32,
   parameter int          IDX_W    = 3,
   parameter logic [47:0] SRC_MAC  = 48'h0001_0203_0405,
   parameter logic [31:0] SRC_IP   = 32'hC0A8_0B2A,
   parameter logic [15:0] SRC_PORT = 16'd4000,
   parameter logic [31:0] DST_IP   = 32'hC0A8_0B19,
   parameter logic [15:0] DST_PORT = 16'd0,
   parameter logic [47:0] DST_MAC  = 48'h0
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   import ors_pkg::*;

   always_comb begin
      addr = ADDR_W'(A_SMAC_LO);
      data = '0;
      case (idx)
         IDX_W'(0): begin addr = ADDR_W'(A_SMAC_LO); data = DATA_W'(SRC_MAC[31:0]);  end
         IDX_W'(1): begin addr = ADDR_W'(A_SMAC_HI); data = DATA_W'(SRC_MAC[47:32]); end
         IDX_W'(2): begin addr = ADDR_W'(A_SIP);     data = DATA_W'(SRC_IP);         end
         IDX_W'(3): begin addr = ADDR_W'(A_SPORT);   data = DATA_W'(SRC_PORT);       end
         IDX_W'(4): begin addr = ADDR_W'(A_DIP);     data = DATA_W'(DST_IP);         end
         IDX_W'(5): begin addr = ADDR_W'(A_DPORT);   data = DATA_W'(DST_PORT);       end
         IDX_W'(6): begin addr = ADDR_W'(A_DMAC_LO); data = DATA_W'(DST_MAC[31:0]);  end
         default:   begin addr = ADDR_W'(A_DMAC_HI); data = DATA_W'(DST_MAC[47:32]); end
      endcase
   end

endmodule

// File: rtl/ors_busy_poll.sv
module ors_busy_poll #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [DATA_W-1:0] rd_data,
   output logic              clear
);

   logic phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) phase_q <= 1'b0;
      else                   phase_q <= ~phase_q;
   end

   assign clear = active & phase_q & ~rd_data[0];

   // R5
   clear_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> $past(active));

endmodule

// File: rtl/offload_reg_seq.sv
module offload_reg_seq #(
   parameter int          ADDR_W       = 4,
   parameter int          DATA_W       = 32,
   parameter int          DEB_W        = 20,
   parameter logic [31:0] TX_TOTAL_LEN = 32'h0010_0000,
   parameter logic [47:0] SRC_MAC      = 48'h0001_0203_0405,
   parameter logic [31:0] SRC_IP       = 32'hC0A8_0B2A,
   parameter logic [15:0] SRC_PORT     = 16'd4000,
   parameter logic [31:0] DST_IP       = 32'hC0A8_0B19,
   parameter logic [15:0] DST_PORT     = 16'd0,
   parameter logic [47:0] DST_MAC      = 48'h0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_btn,
   input  logic              mode_rx,
   input  logic              pkt_jumbo,
   input  logic              conn_on,
   input  logic [DATA_W-1:0] reg_rd_data,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_wr_data
);
   import ors_pkg::*;

   localparam int NPARAM = CFG_WORDS;
   localparam int IDX_W  = $clog2(NPARAM);

   initial begin
      assert (ADDR_W >= 4) else $error("ADDR_W must be at least 4");
      assert (DATA_W >= 32) else $error("DATA_W must be at least 32");
      assert (DEB_W >= 0 && DEB_W <= 30) else $error("DEB_W out of range");
   end

   seq_state_e        state_q, state_d;
   logic [IDX_W-1:0]  idx_q;
   logic              conn_q;
   logic              conn_rise;
   logic              press;
   logic              poll_active;
   logic              poll_clear;
   logic [ADDR_W-1:0] tbl_addr;
   logic [DATA_W-1:0] tbl_data;
   logic [15:0]       seg_len;

   ors_debounce #(.CNT_W(DEB_W)) u_deb (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_raw (start_btn),
      .press   (press)
   );

   ors_cfg_table #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
      .SRC_MAC(SRC_MAC), .SRC_IP(SRC_IP), .SRC_PORT(SRC_PORT),
      .DST_IP(DST_IP), .DST_PORT(DST_PORT), .DST_MAC(DST_MAC)
   ) u_tbl (
      .idx  (idx_q),
      .addr (tbl_addr),
      .data (tbl_data)
   );

   assign poll_active = (state_q == ST_WBUSY1) || (state_q == ST_WBUSY2) ||
                        (state_q == ST_TXEND);

   ors_busy_poll #(.DATA_W(DATA_W)) u_poll (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (poll_active),
      .rd_data (reg_rd_data),
      .clear   (poll_clear)
   );

   assign conn_rise = conn_on & ~conn_q;
   assign seg_len   = pkt_jumbo ? SEG_JUMBO : SEG_STD;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:    if (press) state_d = ST_SETP;
         ST_SETP:    if (idx_q == IDX_W'(NPARAM-1)) state_d = ST_CLRRST;
         ST_CLRRST:  state_d = ST_WBUSY1;
         ST_WBUSY1:  if (poll_clear) state_d = ST_WOPEN;
         ST_WOPEN:   if (conn_rise) state_d = mode_rx ? ST_WCLOSE : ST_TXLEN;
         ST_TXLEN:   state_d = ST_PKTLEN;
         ST_PKTLEN:  state_d = ST_TXCMD;
         ST_TXCMD:   state_d = ST_WBUSY2;
         ST_WBUSY2:  if (poll_clear) state_d = ST_TXCLOSE;
         ST_TXCLOSE: state_d = ST_TXEND;
         ST_TXEND:   if (poll_clear) state_d = ST_WOPEN;
         ST_WCLOSE:  if (!conn_on) state_d = ST_RXEND;
         ST_RXEND:   state_d = ST_WOPEN;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         conn_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         conn_q  <= conn_on;
         if (state_q == ST_SETP) idx_q <= idx_q + 1'b1;
         else                    idx_q <= '0;
      end
   end

   always_comb begin
      reg_wr_en   = 1'b0;
      reg_addr    = ADDR_W'(A_CMD);
      reg_wr_data = '0;
      case (state_q)
         ST_SETP: begin
            reg_wr_en   = 1'b1;
            reg_addr    = tbl_addr;
            reg_wr_data = tbl_data;
         end
         ST_CLRRST: begin
            reg_wr_en   = 1'b1;
            reg_addr    = ADDR_W'(A_RESET);
         end
         ST_TXLEN: begin
            reg_wr_en   = 1'b1;
            reg_addr    = ADDR_W'(A_TOTLEN);
            reg_wr_data = DATA_W'(TX_TOTAL_LEN);
         end
         ST_PKTLEN: begin
            reg_wr_en   = 1'b1;
            reg_addr    = ADDR_W'(A_PKTLEN);
            reg_wr_data = DATA_W'(seg_len);
         end
         ST_TXCMD: begin
            reg_wr_en   = 1'b1;
            reg_wr_data = DATA_W'(CMD_SEND);
         end
         ST_TXCLOSE: begin
            reg_wr_en   = 1'b1;
            reg_wr_data = DATA_W'(CMD_CLOSE);
         end
         default: ;
      endcase
   end

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !reg_wr_en);

   // R3
   cfg_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CLRRST) |-> $past(state_q, 9) == ST_IDLE);

   // R4
   rst_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WBUSY1 && $past(state_q) == ST_CLRRST) |->
         $past(reg_wr_en) && $past(reg_addr) == ADDR_W'(A_RESET) && $past(reg_wr_data) == '0);

   // R5
   busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_active && state_d != state_q) |->
         !reg_rd_data[0] && $past(reg_addr) == ADDR_W'(A_CMD));

   // R6
   send_after_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WBUSY2 && $past(state_q) == ST_TXCMD) |->
         $past(reg_addr) == ADDR_W'(A_CMD) && $past(reg_wr_data) == DATA_W'(CMD_SEND));

   // R9
   rx_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RXEND) |-> !$past(conn_on));

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_q != ST_SETP) |=> state_q != ST_SETP);

endmodule

// File: tb/sim_offload_reg_seq.sv
module sim_offload_reg_seq;
   import ors_pkg::*;

   localparam int          AW  = 4;
   localparam int          DW  = 32;
   localparam int          DBW = 4;
   localparam logic [31:0] TOT = 32'h0010_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_btn = 1'b0;
   logic          mode_rx = 1'b0;
   logic          pkt_jumbo = 1'b0;
   logic          conn_on = 1'b0;
   logic [DW-1:0] rd_data = '0;
   logic [AW-1:0] addr;
   logic          wr_en;
   logic [DW-1:0] wr_data;

   always #2 clk = ~clk;

   offload_reg_seq #(.ADDR_W(AW), .DATA_W(DW), .DEB_W(DBW), .TX_TOTAL_LEN(TOT)) u0 (
      .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .mode_rx(mode_rx),
      .pkt_jumbo(pkt_jumbo), .conn_on(conn_on), .reg_rd_data(rd_data),
      .reg_addr(addr), .reg_wr_en(wr_en), .reg_wr_data(wr_data)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int busy_cnt = 0;
   int clr_cyc  = 0;
   int wn = 0;
   int rp = 0;
   logic [AW-1:0] wa [0:255];
   logic [DW-1:0] wd [0:255];
   int            wt [0:255];

   always @(posedge clk) cyc <= cyc + 1;

   // engine model: registered read, busy counter started by reset/command writes
   always @(posedge clk) begin
      rd_data <= (addr == AW'(A_CMD)) ? DW'(busy_cnt != 0) : 32'h5A5A_5A5A;
      if (busy_cnt == 1) clr_cyc <= cyc;
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (rst_n && wr_en) begin
         if (wn < 256) begin
            wa[wn] <= addr; wd[wn] <= wr_data; wt[wn] <= cyc;
         end
         wn <= wn + 1;
         if (addr == AW'(A_RESET) || addr == AW'(A_CMD))
            busy_cnt <= 2 + int'($urandom_range(18, 0));
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] cfg_val(input int i);
      case (i)
         0: return 32'h0203_0405;
         1: return 32'h0000_0001;
         2: return 32'hC0A8_0B2A;
         3: return 32'd4000;
         4: return 32'hC0A8_0B19;
         default: return 32'h0;
      endcase
   endfunction

   task automatic next_wr(input logic [3:0] ea, input logic [31:0] ed, input string req);
      int t = 0;
      while (wn <= rp && t < 400) begin @(negedge clk); t++; end
      if (wn <= rp) begin
         chk(1'b0, req, "missing write", wn, rp + 1);
      end else begin
         chk(wa[rp] == AW'(ea), req, "write addr", wa[rp], ea);
         chk(wd[rp] == ed, req, "write data", wd[rp], ed);
         rp++;
      end
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int pcyc;
      int base;
      void'($urandom(32'h1234_5678));
      repeat (5) @(negedge clk);
      chk(wr_en == 1'b0, "R1", "wr_en in reset", wr_en, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(wn == 0, "R1", "writes while idle", wn, 0);

      // short glitch must be rejected
      start_btn = 1'b1; repeat (6) @(negedge clk); start_btn = 1'b0;
      repeat (40) @(negedge clk);
      chk(wn == 0, "R2", "writes after glitch", wn, 0);

      // real press
      start_btn = 1'b1; pcyc = cyc;
      repeat (40) @(negedge clk); start_btn = 1'b0;
      for (int i = 0; i < 8; i++) next_wr(4'(4 + i), cfg_val(i), "R3");
      chk(wt[0] - pcyc >= (1 << DBW), "R2", "press latency", wt[0] - pcyc, 1 << DBW);
      chk(wt[7] - wt[0] == 7, "R3", "burst span", wt[7] - wt[0], 7);
      next_wr(A_RESET, 32'h0, "R4");
      chk(wt[8] == wt[7] + 1, "R4", "reset write cycle", wt[8], wt[7] + 1);
      @(negedge clk);
      chk(addr == AW'(A_CMD), "R5", "poll address", addr, A_CMD);
      repeat (50) @(negedge clk);
      chk(wn == rp, "R5", "writes during poll/wait", wn, rp);

      // press outside idle
      start_btn = 1'b1; repeat (40) @(negedge clk); start_btn = 1'b0;
      repeat (30) @(negedge clk);
      chk(wn == rp, "R10", "writes after late press", wn, rp);

      for (int it = 0; it < 10; it++) begin
         if (it == 0)      begin mode_rx = 1'b0; pkt_jumbo = 1'b0; end
         else if (it == 1) begin mode_rx = 1'b1; pkt_jumbo = 1'b1; end
         else if (it == 2) begin mode_rx = 1'b0; pkt_jumbo = 1'b1; end
         else begin
            mode_rx = 1'($urandom_range(1, 0));
            pkt_jumbo = 1'($urandom_range(1, 0));
         end
         @(negedge clk);
         conn_on = 1'b1;
         if (!mode_rx) begin
            next_wr(A_TOTLEN, TOT, "R6");
            next_wr(A_PKTLEN, pkt_jumbo ? 32'd8960 : 32'd1460, "R7");
            next_wr(A_CMD, 32'd0, "R6");
            chk(wt[rp-1] == wt[rp-3] + 2, "R6", "tx burst span", wt[rp-1] - wt[rp-3], 2);
            next_wr(A_CMD, 32'd3, "R8");
            chk(wt[rp-1] > clr_cyc, "R8", "close after busy clear", wt[rp-1], clr_cyc + 1);
            wait (busy_cnt == 0);
            conn_on = 1'b0;
            repeat (20) @(negedge clk);
            chk(wn == rp, "R8", "quiet after close", wn, rp);
         end else begin
            base = wn;
            repeat (10 + int'($urandom_range(50, 0))) @(negedge clk);
            chk(wn == base, "R9", "writes during rx", wn, base);
            conn_on = 1'b0;
            repeat (10) @(negedge clk);
            chk(wn == base, "R9", "writes after rx close", wn, base);
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule